// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies word addresses to a synchronous burst memory. A burst starts when the cache-controller strobe is asserted. It also starts when the processor strobe is asserted while the primary chip enable is active. On that clock edge the block takes in the full external address and registers the ordering mode. After that it generates the next addresses itself. Only the low two address bits move, and only on cycles where the advance input is high. The upper bits keep their loaded value for the whole burst.

Two orderings are available, selected by a mode input. The mode is sampled when the burst starts.
- **Linear** (mode low): the low bits count up modulo four from the start value, for example 2, 3, 0, 1.
- **Interleaved** (mode high): the low bits equal the start value XOR the beat number, for example 1, 0, 3, 2.

A board that leaves the mode pin unconnected should pull it high, which selects interleaved order.

A small state machine has three states:
- `ST_IDLE`: nothing loaded since reset.
- `ST_BURST`: a beat other than the fourth of the group.
- `ST_LAST`: the fourth beat.

Its transitions are:
- `T_LOAD`: any state goes to `ST_BURST` on a qualified strobe, with the beat reset to 0.
- `T_STEP`: `ST_BURST` stays in `ST_BURST` on advance.
- `T_REACH_LAST`: `ST_BURST` goes to `ST_LAST` when advance reaches beat 3.
- `T_WRAP`: `ST_LAST` goes to `ST_BURST` on advance, with the beat back at 0.
- `T_HOLD`: no strobe and no advance leaves the state unchanged. This includes `ST_IDLE`, which ignores advance.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `addr_out` is 0, `beat_pos` is 0, and `burst_last` and `burst_active` are 0.
- R2: A high `strb_ctrl` at a rising edge loads `addr_in` into `addr_out` at that edge, whatever `ce_primary` is. It also sets `beat_pos` to 0 and `burst_active` to 1.
- R3: A high `strb_proc` loads the address only when `ce_primary` is 1. With `ce_primary` at 0 and `strb_ctrl` low, all outputs keep their values.
- R4: With `order_sel` = 0 at the load, the low two bits of `addr_out` equal (start + `beat_pos`) mod 4.
- R5: With `order_sel` = 1 at the load, the low two bits of `addr_out` equal start XOR `beat_pos`.
- R6: With `adv` high, no qualified strobe and a burst active, `beat_pos` increments modulo 4 at the edge. The upper address bits do not change.
- R7: With `adv` low and no qualified strobe, every output keeps its value.
- R8: When a qualified strobe and `adv` are high in the same cycle, the load wins: `beat_pos` becomes 0 and `addr_out` becomes `addr_in`.
- R9: Before the first load, `adv` has no effect and `burst_active` stays 0.
- R10: A change of `order_sel` in the middle of a burst does not change the ordering until the next load.
- R11: `burst_last` is 1 exactly when a burst is active and `beat_pos` is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External start address |
| strb_proc | input | 1 | Processor-side address strobe, gated by `ce_primary` |
| strb_ctrl | input | 1 | Controller-side address strobe, always honoured |
| ce_primary | input | 1 | Primary chip enable |
| adv | input | 1 | Burst advance |
| order_sel | input | 1 | 0 = linear, 1 = interleaved; sampled at load |
| addr_out | output | ADDR_W | Current word address |
| beat_pos | output | BEAT_W | Beat number within the burst |
| burst_last | output | 1 | Current beat is the final one of the group |
| burst_active | output | 1 | A burst has been loaded |

## Verification
The two functions that can fall in the same cycle are loading a new start address and advancing the current burst. The bench provokes this by raising a strobe together with `adv` in the middle of a burst. It does so with the controller strobe, and again with both strobes together. The scoreboard expects beat 0 and the new address, not the stepped old one. A second collision is `order_sel` toggling in the middle of a burst while `adv` steps. Here the expected sequence keeps the ordering that was captured at the load.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
package bseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_LAST  = 2'd2
    } bseq_state_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } bseq_order_e;

endpackage

// File: rtl/bseq_strobe_qual.sv
`timescale 1ns/1ps
module bseq_strobe_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_proc,
    input  logic strb_ctrl,
    input  logic ce_primary,
    output logic load
);

    logic proc_ok;

    always_comb begin
        proc_ok = strb_proc & ce_primary;
        load    = strb_ctrl | proc_ok;
    end

    // R3: a processor strobe without chip enable never starts a burst on its own
    a_r3_proc_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_proc && !ce_primary && !strb_ctrl) |-> !load);

    // R2: the controller strobe is always honoured
    a_r2_ctrl_honoured: assert property (@(posedge clk) disable iff (!rst_n)
        strb_ctrl |-> load);

endmodule

// File: rtl/bseq_order.sv
`timescale 1ns/1ps
module bseq_order #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_bits,
    input  logic [BEAT_W-1:0] beat,
    input  bseq_pkg::bseq_order_e mode,
    output logic [BEAT_W-1:0] low_bits
);

    logic [BEAT_W-1:0] lin_bits;
    logic [BEAT_W-1:0] ilv_bits;

    always_comb lin_bits = start_bits + beat;

    genvar gi;
    generate
        for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
            assign ilv_bits[gi] = start_bits[gi] ^ beat[gi];
        end
    endgenerate

    always_comb begin
        unique case (mode)
            bseq_pkg::ORD_LINEAR:     low_bits = lin_bits;
            bseq_pkg::ORD_INTERLEAVE: low_bits = ilv_bits;
            default:                  low_bits = lin_bits;
        endcase
    end

endmodule

// File: rtl/bseq_ctrl.sv
`timescale 1ns/1ps
module bseq_ctrl #(
    parameter int BEAT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic adv,
    output bseq_pkg::bseq_state_e state,
    output logic [BEAT_W-1:0] beat_q
);
    import bseq_pkg::*;

    localparam logic [BEAT_W-1:0] BEAT_MAX = '1;
    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    bseq_state_e       state_q, state_d;
    logic [BEAT_W-1:0] beat_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // next state and beat
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        if (load) begin
            // T_LOAD
            state_d = ST_BURST;
            beat_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_BURST: begin
                    if (adv) begin
                        beat_d = beat_q + BEAT_ONE;
                        // T_REACH_LAST or T_STEP
                        state_d = (beat_d == BEAT_MAX) ? ST_LAST : ST_BURST;
                    end
                end
                ST_LAST: begin
                    if (adv) begin
                        // T_WRAP
                        beat_d  = '0;
                        state_d = ST_BURST;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    beat_d  = '0;
                end
            endcase
        end
    end

    always_comb state = state_q;

    // R8: load beats advance
    a_r8_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_q == '0 && state_q == ST_BURST));

    // R7: nothing moves without strobe or advance
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> ($stable(beat_q) && $stable(state_q)));

    // R6: one step per advance
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv && state_q != ST_IDLE) |=>
            (beat_q == BEAT_W'($past(beat_q) + BEAT_ONE)));

    // R9: idle ignores advance
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && state_q == ST_IDLE) |=> (state_q == ST_IDLE && beat_q == '0));

    // R11: final state matches final beat
    a_r11_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> ((state_q == ST_LAST) == (beat_q == BEAT_MAX)));

endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strb_proc,
    input  logic              strb_ctrl,
    input  logic              ce_primary,
    input  logic              adv,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BEAT_W-1:0] beat_pos,
    output logic              burst_last,
    output logic              burst_active
);
    import bseq_pkg::*;

    localparam int UP_W = ADDR_W - BEAT_W;

    logic              load;
    bseq_state_e       state;
    logic [BEAT_W-1:0] beat_q;
    logic [UP_W-1:0]   upper_q;
    logic [BEAT_W-1:0] start_q;
    bseq_order_e       mode_q;
    logic [BEAT_W-1:0] low_bits;

    bseq_strobe_qual u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .strb_proc  (strb_proc),
        .strb_ctrl  (strb_ctrl),
        .ce_primary (ce_primary),
        .load       (load)
    );

    bseq_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .adv    (adv),
        .state  (state),
        .beat_q (beat_q)
    );

    // start address and mode capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            mode_q  <= ORD_LINEAR;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:BEAT_W];
            start_q <= addr_in[BEAT_W-1:0];
            mode_q  <= bseq_order_e'(order_sel);
        end
    end

    bseq_order #(.BEAT_W(BEAT_W)) u_order (
        .start_bits (start_q),
        .beat       (beat_q),
        .mode       (mode_q),
        .low_bits   (low_bits)
    );

    // outputs
    always_comb begin
        addr_out     = {upper_q, low_bits};
        beat_pos     = beat_q;
        burst_last   = (state == ST_LAST);
        burst_active = (state != ST_IDLE);
    end

    // R2: a loaded address appears whole at the next output
    a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_out == $past(addr_in)));

    // R6: upper bits fixed within a burst
    a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    // R7: full address holds when idle on both controls
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(addr_out));

endmodule

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strb_proc = 1'b0, strb_ctrl = 1'b0, ce_primary = 1'b0;
    logic          adv = 1'b0, order_sel = 1'b0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_pos;
    logic          burst_last, burst_active;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    beat;
        logic          last;
        logic          act;
        string         tag;
    } exp_t;

    exp_t q[$];

    // reference state
    logic          m_act = 0;
    logic [AW-3:0] m_up = '0;
    logic [1:0]    m_start = '0, m_beat = '0;
    logic          m_mode = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .strb_proc(strb_proc), .strb_ctrl(strb_ctrl), .ce_primary(ce_primary),
        .adv(adv), .order_sel(order_sel),
        .addr_out(addr_out), .beat_pos(beat_pos),
        .burst_last(burst_last), .burst_active(burst_active)
    );

    function automatic exp_t model_out(string tag);
        exp_t e;
        logic [1:0] lo;
        lo = m_mode ? (m_start ^ m_beat) : (m_start + m_beat);
        e.addr = {m_up, lo};
        e.beat = m_beat;
        e.act  = m_act;
        e.last = m_act && (m_beat == 2'd3);
        e.tag  = tag;
        return e;
    endfunction

    task automatic cyc(input logic c, input logic p, input logic ce,
                       input logic a, input logic md, input logic [AW-1:0] ad,
                       input string tag);
        @(negedge clk);
        strb_ctrl = c; strb_proc = p; ce_primary = ce;
        adv = a; order_sel = md; addr_in = ad;
        if (c || (p && ce)) begin
            m_up = ad[AW-1:2]; m_start = ad[1:0];
            m_beat = 2'd0; m_mode = md; m_act = 1'b1;
        end else if (a && m_act) begin
            m_beat = m_beat + 2'd1;
        end
        q.push_back(model_out(tag));
    endtask

    task automatic compare(input exp_t e);
        total++;
        if (addr_out !== e.addr || beat_pos !== e.beat ||
            burst_last !== e.last || burst_active !== e.act) begin
            bad++;
            $display("FAIL %s: got addr=%h beat=%0d last=%b act=%b, expected addr=%h beat=%0d last=%b act=%b",
                     e.tag, addr_out, beat_pos, burst_last, burst_active,
                     e.addr, e.beat, e.last, e.act);
        end
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (rst_n && q.size() > 0) compare(q.pop_front());
    end

    // watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare(model_out("R1"));           // reset state
        @(negedge clk);
        rst_n = 1'b1;

        cyc(0,0,1,1,0,20'h00000,"R9");      // advance before any load
        cyc(0,0,1,1,1,20'h00000,"R9");
        cyc(1,0,0,0,0,20'hABCD2,"R2");      // controller strobe, ce low
        cyc(0,0,0,1,0,20'h00000,"R4");      // linear 2,3,0,1
        cyc(0,0,0,1,0,20'h00000,"R4");
        cyc(0,0,0,1,0,20'h00000,"R11");     // beat 3, last
        cyc(0,0,0,1,0,20'h00000,"R6");      // wrap to beat 0
        cyc(0,0,0,0,0,20'h11111,"R7");      // hold
        cyc(0,0,1,0,1,20'h22223,"R7");
        cyc(0,1,0,0,0,20'h55555,"R3");      // proc strobe, ce low: ignored
        cyc(0,1,0,1,0,20'h55555,"R3");      // ignored, but advance steps
        cyc(0,1,1,0,1,20'h12341,"R3");      // proc strobe, ce high
        cyc(0,0,1,1,1,20'h00000,"R5");      // interleave 1,0,3,2
        cyc(0,0,1,1,0,20'h00000,"R10");     // mode toggles mid-burst
        cyc(0,0,1,1,0,20'h00000,"R10");
        cyc(1,0,1,1,0,20'h0FFF3,"R8");      // load and advance together
        cyc(0,0,1,1,0,20'h00000,"R6");      // 3 -> 0, upper unchanged
        cyc(1,1,1,1,1,20'hF00F3,"R8");      // both strobes with advance
        cyc(0,0,0,1,1,20'h00000,"R5");      // interleave from 3: 3,2,1,0
        cyc(0,0,0,1,1,20'h00000,"R5");
        cyc(0,0,0,1,1,20'h00000,"R11");
        cyc(0,0,0,0,1,20'h00000,"R7");

        @(negedge clk);
        strb_ctrl = 0; strb_proc = 0; adv = 0;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule